// File: doc/BRIEF.md
# Self-Triggered Pulse Feature Extractor

This block processes one channel of free-running ADC samples taken from a calorimeter preamplifier. A new sample arrives on every clock and no external trigger exists, so the block has to find pulses by itself. While the line is quiet it tracks the signal's resting level with a shift-based moving average. A sample that rises above that level by more than a programmable threshold opens a pulse. From then until the signal settles back, the resting level is frozen.

Inside a pulse the block follows the running peak. It declares the maximum once two samples in a row stay under the peak. After the maximum it watches for a renewed rise, which marks a second pulse landing on the tail of the first. When the signal drops back to or below the threshold, the block builds one hit record. The record holds the global time-stamp of the peak sample, the peak minus the frozen resting level, and a pile-up flag. The record is offered on a valid/ready stream. The time-stamp is a free-running count supplied by the shared sampling clock domain.

Top module: `pulse_feature_extractor`

## Requirements
- R1: After reset `hit_valid` is 0, and the first sample taken after reset is loaded directly as the resting level; no pulse can start on that sample.
- R2: On every sample that arrives while no pulse is open and that does not exceed resting level + threshold, the resting level updates as level := level + ((sample − level) >>> SHIFT), with arithmetic (floor) shift and SHIFT = 4 by default.
- R3: A pulse opens on a sample strictly greater than resting level + `thresh`; a sample exactly equal to that sum opens nothing.
- R4: The resting level does not change from the opening sample up to and including the sample that closes the pulse.
- R5: Within a pulse, a sample greater than or equal to the running peak becomes the new peak (on ties the later sample wins); the maximum is declared after two consecutive samples below the peak, and a sample at or above the peak in between restarts that count.
- R6: `hit_ts` equals the value of `ts_in` presented together with the peak sample.
- R7: `hit_amp` equals peak − resting level, zero-extended to AMP_W bits.
- R8: After the maximum is declared, `hit_pileup` is set if some sample exceeds the lowest sample seen since the maximum by more than `pileup_delta`; an excess of exactly `pileup_delta` does not set it.
- R9: A pulse closes on the first sample at or below resting level + threshold, even one that arrives before the maximum is declared; `hit_valid` rises on the clock edge that takes that closing sample.
- R10: While `hit_valid` is 1 and `hit_ready` is 0, the record stays valid and does not change.
- R11: A record that closes while the output still holds an unaccepted record (with `hit_ready` low) is discarded, and the held record is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_in | input | SAMPLE_W | ADC sample, one per clock |
| ts_in | input | TS_W | Global time-stamp count |
| thresh | input | SAMPLE_W | Pulse threshold above the resting level |
| pileup_delta | input | SAMPLE_W | Rise after the maximum that flags pile-up |
| hit_ready | input | 1 | Consumer accepts the record |
| hit_valid | output | 1 | Record available |
| hit_ts | output | TS_W | Time-stamp of the peak sample |
| hit_amp | output | AMP_W | Peak minus resting level |
| hit_pileup | output | 1 | Second pulse seen on the tail |

## Verification
The embedded properties assume that `thresh` and `pileup_delta` stay constant while the block runs, and that the sum of the resting level and the threshold fits the sample range. The amplitude property depends on both. The stimulus sets both inputs once before reset and never changes them. It keeps every sample well inside 14 bits, and it always closes a pulse with a sample near the resting level, so a closing sample can never also read as a new rise.

// File: rtl/pfx_pkg.sv
// Package pfx_pkg
// Shared types for the pulse feature extractor.
package pfx_pkg;

    // Pulse detector phases: waiting, climbing towards the peak, on the tail.
    typedef enum logic [1:0] {
        DET_IDLE = 2'd0,
        DET_RISE = 2'd1,
        DET_TAIL = 2'd2
    } det_state_e;

endpackage

// File: rtl/pfx_baseline.sv
// Module pfx_baseline
// Follows the resting level of the sample stream with a shift-based
// moving average. The first sample after reset is loaded directly.
// Assumes: update_i is low whenever a pulse is open or the sample
// is above threshold; the caller owns that decision.
module pfx_baseline #(
    parameter int SAMPLE_W = 14,
    parameter int SHIFT    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                update_i,
    output logic [SAMPLE_W-1:0] base_o,
    output logic                primed_o
);
    localparam int DW = SAMPLE_W + 1;

    logic [SAMPLE_W-1:0] base_q;
    logic                primed_q;
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] step;

    // Signed distance from the level to the sample, scaled down.
    always_comb begin
        diff = $signed({1'b0, sample_i}) - $signed({1'b0, base_q});
        step = diff >>> SHIFT;
    end

    // Load on the first sample, then move by the scaled distance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            primed_q <= 1'b0;
        end else if (!primed_q) begin
            base_q   <= sample_i;
            primed_q <= 1'b1;
        end else if (update_i) begin
            base_q   <= base_q + step[SAMPLE_W-1:0];
        end
    end

    assign base_o   = base_q;
    assign primed_o = primed_q;

    // R1: a primed level never returns to unprimed without reset.
    assert_primed_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |=> primed_q);

endmodule

// File: rtl/pfx_detector.sv
// Module pfx_detector
// Finds a pulse above the trigger level, follows its peak, declares
// the maximum after two falling samples and watches the tail for a
// renewed rise. It signals the closing sample with emit_o.
// Assumes: level_i is constant while busy_o is high (the level
// follower is frozen then) and delta_i is static.
module pfx_detector
    import pfx_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int TS_W     = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [TS_W-1:0]     ts_i,
    input  logic [SAMPLE_W:0]   level_i,
    input  logic [SAMPLE_W-1:0] delta_i,
    output logic                above_o,
    output logic                busy_o,
    output logic                emit_o,
    output logic [SAMPLE_W-1:0] peak_o,
    output logic [TS_W-1:0]     peak_ts_o,
    output logic                pileup_o
);
    localparam int RW = SAMPLE_W + 2;

    det_state_e          state_q;
    logic [SAMPLE_W-1:0] peak_q;
    logic [TS_W-1:0]     peak_ts_q;
    logic                drop_q;
    logic [SAMPLE_W-1:0] trough_q;
    logic                pu_q;
    logic                above;
    logic                at_peak;
    logic                rise_hit;

    // Comparisons against the trigger level, the peak and the trough.
    always_comb begin
        above    = {1'b0, sample_i} > level_i;
        at_peak  = sample_i >= peak_q;
        rise_hit = {2'b00, sample_i} > ({2'b00, trough_q} + {2'b00, delta_i});
    end

    // Phase sequencing and per-pulse feature registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= DET_IDLE;
            peak_q    <= '0;
            peak_ts_q <= '0;
            drop_q    <= 1'b0;
            trough_q  <= '0;
            pu_q      <= 1'b0;
        end else begin
            case (state_q)
                DET_IDLE: begin
                    if (enable_i && above) begin
                        state_q   <= DET_RISE;
                        peak_q    <= sample_i;
                        peak_ts_q <= ts_i;
                        drop_q    <= 1'b0;
                        pu_q      <= 1'b0;
                    end
                end
                DET_RISE: begin
                    if (!above) begin
                        state_q <= DET_IDLE;
                    end else if (at_peak) begin
                        peak_q    <= sample_i;
                        peak_ts_q <= ts_i;
                        drop_q    <= 1'b0;
                    end else if (drop_q) begin
                        state_q  <= DET_TAIL;
                        trough_q <= sample_i;
                    end else begin
                        drop_q <= 1'b1;
                    end
                end
                DET_TAIL: begin
                    if (!above) begin
                        state_q <= DET_IDLE;
                    end else begin
                        if (sample_i < trough_q) trough_q <= sample_i;
                        if (rise_hit)            pu_q     <= 1'b1;
                    end
                end
                default: state_q <= DET_IDLE;
            endcase
        end
    end

    assign above_o   = above;
    assign busy_o    = (state_q != DET_IDLE);
    assign emit_o    = (state_q != DET_IDLE) && !above;
    assign peak_o    = peak_q;
    assign peak_ts_o = peak_ts_q;
    assign pileup_o  = pu_q;

    // R8: the pile-up mark is clear while still climbing to the peak.
    assert_no_pileup_in_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DET_RISE) |-> !pu_q);

    // R5: every sample tracked on the tail is below the declared peak.
    assert_trough_below_peak_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DET_TAIL) |-> (trough_q < peak_q));

    // R5: the peak never falls while a pulse is open.
    assert_peak_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != DET_IDLE) && !emit_o |=> (peak_q >= $past(peak_q)));

endmodule

// File: rtl/pfx_hit_reg.sv
// Module pfx_hit_reg
// Single-entry output holding register with a valid/ready handshake.
// A new record loads only when the register is empty or is being
// accepted in the same cycle; otherwise the new record is discarded.
module pfx_hit_reg #(
    parameter int TS_W  = 48,
    parameter int AMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TS_W-1:0]  ts_i,
    input  logic [AMP_W-1:0] amp_i,
    input  logic             pu_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [TS_W-1:0]  ts_o,
    output logic [AMP_W-1:0] amp_o,
    output logic             pu_o
);
    logic             valid_q;
    logic [TS_W-1:0]  ts_q;
    logic [AMP_W-1:0] amp_q;
    logic             pu_q;
    logic             room;

    // Space exists when empty or when the held record leaves now.
    always_comb room = !valid_q || ready_i;

    // Capture, hold or release the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ts_q    <= '0;
            amp_q   <= '0;
            pu_q    <= 1'b0;
        end else if (load_i && room) begin
            valid_q <= 1'b1;
            ts_q    <= ts_i;
            amp_q   <= amp_i;
            pu_q    <= pu_i;
        end else if (ready_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign ts_o    = ts_q;
    assign amp_o   = amp_q;
    assign pu_o    = pu_q;

    // R10: a stalled record stays valid and unchanged.
    assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && !ready_i |=> valid_q && $stable(ts_q) && $stable(amp_q) && $stable(pu_q));

    // R9: a closing pulse with room appears on the next cycle.
    assert_load_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && room |=> valid_q && (ts_q == $past(ts_i)));

endmodule

// File: rtl/pulse_feature_extractor.sv
// Module pulse_feature_extractor
// One channel of self-triggered hit finding on a free-running sample
// stream: level follower, pulse detector and output register.
// Assumes: thresh and pileup_delta are static during operation, and
// AMP_W >= SAMPLE_W.
module pulse_feature_extractor
    import pfx_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int TS_W     = 48,
    parameter int AMP_W    = 16,
    parameter int SHIFT    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [TS_W-1:0]     ts_in,
    input  logic [SAMPLE_W-1:0] thresh,
    input  logic [SAMPLE_W-1:0] pileup_delta,
    input  logic                hit_ready,
    output logic                hit_valid,
    output logic [TS_W-1:0]     hit_ts,
    output logic [AMP_W-1:0]    hit_amp,
    output logic                hit_pileup
);
    logic [SAMPLE_W-1:0] base;
    logic                base_ok;
    logic [SAMPLE_W:0]   level;
    logic                above;
    logic                busy;
    logic                emit;
    logic [SAMPLE_W-1:0] peak;
    logic [TS_W-1:0]     peak_ts;
    logic                pu;
    logic                follow;
    logic [SAMPLE_W-1:0] amp_raw;
    logic [AMP_W-1:0]    amp_ext;

    // Trigger level, follower enable and amplitude of the current pulse.
    always_comb begin
        level   = {1'b0, base} + {1'b0, thresh};
        follow  = !busy && !above;
        amp_raw = peak - base;
        amp_ext = AMP_W'(amp_raw);
    end

    pfx_baseline #(
        .SAMPLE_W (SAMPLE_W),
        .SHIFT    (SHIFT)
    ) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_in),
        .update_i (follow),
        .base_o   (base),
        .primed_o (base_ok)
    );

    pfx_detector #(
        .SAMPLE_W (SAMPLE_W),
        .TS_W     (TS_W)
    ) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (base_ok),
        .sample_i  (sample_in),
        .ts_i      (ts_in),
        .level_i   (level),
        .delta_i   (pileup_delta),
        .above_o   (above),
        .busy_o    (busy),
        .emit_o    (emit),
        .peak_o    (peak),
        .peak_ts_o (peak_ts),
        .pileup_o  (pu)
    );

    pfx_hit_reg #(
        .TS_W  (TS_W),
        .AMP_W (AMP_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (emit),
        .ts_i    (peak_ts),
        .amp_i   (amp_ext),
        .pu_i    (pu),
        .ready_i (hit_ready),
        .valid_o (hit_valid),
        .ts_o    (hit_ts),
        .amp_o   (hit_amp),
        .pu_o    (hit_pileup)
    );

    // R4: the resting level holds still while a pulse is open.
    assert_level_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base));

    // R1: no pulse can be open before the level has been loaded.
    assert_no_pulse_unprimed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !base_ok |=> !busy);

    // R7: any reported amplitude exceeds the threshold.
    assert_amp_above_thresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_amp > AMP_W'(thresh)));

endmodule

// File: tb/sim_pulse_feature_extractor.sv
// Scoreboard bench: the driver pushes the expected record of every
// pulse it shapes; a monitor pops and compares on each handshake.
module sim_pulse_feature_extractor;
    localparam int  CLK_PERIOD = 10;
    localparam int  SW    = 14;
    localparam int  TW    = 48;
    localparam int  AW    = 16;
    localparam int  SH    = 4;
    localparam int  THR   = 50;
    localparam int  DELTA = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] sample_in = '0;
    logic [TW-1:0] ts_in = 48'h0000_FFFF_FFF0;
    logic [SW-1:0] thresh = SW'(THR);
    logic [SW-1:0] pileup_delta = SW'(DELTA);
    logic          hit_ready = 1'b1;
    logic          hit_valid;
    logic [TW-1:0] hit_ts;
    logic [AW-1:0] hit_amp;
    logic          hit_pileup;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    int      bl;
    bit      primed;
    int      shp[$];
    longint  last_ts;
    int      last_amp;
    longint  q_ts[$];
    int      q_amp[$];
    bit      q_pu[$];
    string   q_tag[$];

    pulse_feature_extractor #(
        .SAMPLE_W (SW), .TS_W (TW), .AMP_W (AW), .SHIFT (SH)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .sample_in (sample_in), .ts_in (ts_in),
        .thresh (thresh), .pileup_delta (pileup_delta), .hit_ready (hit_ready),
        .hit_valid (hit_valid), .hit_ts (hit_ts), .hit_amp (hit_amp),
        .hit_pileup (hit_pileup)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running global time-stamp.
    always @(posedge clk) ts_in <= ts_in + 1'b1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One sample per clock, driven a quarter period after the edge.
    task automatic step(input int v);
        @(posedge clk);
        #(CLK_PERIOD/4);
        sample_in = SW'(v);
    endtask

    // Quiet samples; the model level follows R1/R2.
    task automatic flat(input int v, input int n);
        for (int i = 0; i < n; i++) begin
            step(v);
            if (!primed) begin
                bl = v;
                primed = 1'b1;
            end else begin
                bl = bl + ((v - bl) >>> SH);
            end
        end
    endtask

    // Drive shp; the last entry closes the pulse and leaves the level alone.
    task automatic run_pulse(input int pk, input bit pu, input bit keep, input string tag);
        for (int i = 0; i < shp.size(); i++) begin
            step(shp[i]);
            if (i == pk) last_ts = longint'(ts_in);
        end
        last_amp = shp[pk] - bl;
        if (keep) begin
            q_ts.push_back(last_ts);
            q_amp.push_back(last_amp);
            q_pu.push_back(pu);
            q_tag.push_back(tag);
        end
    endtask

    task automatic do_reset(input int first);
        @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        sample_in = SW'(first);
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b1;
        bl = first;
        primed = 1'b1;
    endtask

    // Monitor: each accepted record is compared with the queue head.
    always @(negedge clk) begin
        if (rst_n && hit_valid && hit_ready) begin
            if (q_ts.size() == 0) begin
                chk(1'b0, "R3 unexpected hit ts", longint'(hit_ts), -1);
            end else begin
                string t;
                t = q_tag.pop_front();
                chk(longint'(hit_ts) == q_ts[0], {t, " R6 time-stamp"}, longint'(hit_ts), q_ts[0]);
                chk(int'(hit_amp) == q_amp[0], {t, " R7 amplitude"}, longint'(hit_amp), q_amp[0]);
                chk(hit_pileup == q_pu[0], {t, " R8 pile-up"}, longint'(hit_pileup), longint'(q_pu[0]));
                void'(q_ts.pop_front());
                void'(q_amp.pop_front());
                void'(q_pu.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        primed = 1'b0;
        bl = 0;
        do_reset(100);
        @(negedge clk);
        chk(hit_valid == 1'b0, "R1 valid after reset", longint'(hit_valid), 0);
        flat(100, 20);

        // R5 R6 R7: basic pulse, peak at index 2
        shp = '{200, 500, 800, 700, 600, 100};
        run_pulse(2, 1'b0, 1'b1, "R5 basic");
        flat(100, 10);

        // R3: sample equal to level + threshold starts nothing, R2 moves level
        flat(150, 1);
        flat(100, 10);
        chk(bl == 100, "R2 model level settled", bl, 100);
        // R3 R9: one step above the sum opens, next sample closes before a maximum
        shp = '{151, 100};
        run_pulse(0, 1'b0, 1'b1, "R3 R9 just-over");
        flat(100, 8);

        // R5: plateau ties, latest sample wins
        shp = '{300, 900, 900, 900, 850, 800, 100};
        run_pulse(3, 1'b0, 1'b1, "R5 tie");
        flat(100, 8);

        // R5: a single drop then a higher sample restarts the count
        shp = '{300, 700, 650, 750, 700, 650, 100};
        run_pulse(3, 1'b0, 1'b1, "R5 restart");
        flat(100, 8);

        // R8: rise of 100 above the trough exceeds delta 80
        shp = '{300, 900, 800, 700, 650, 750, 500, 100};
        run_pulse(1, 1'b1, 1'b1, "R8 pile-up");
        flat(100, 8);

        // R8: rise of exactly delta does not flag
        shp = '{300, 900, 800, 700, 650, 730, 500, 100};
        run_pulse(1, 1'b0, 1'b1, "R8 boundary");
        flat(100, 8);

        // R4: long tail at 300 must not pull the level up
        shp = {};
        shp.push_back(200);
        shp.push_back(600);
        for (int i = 0; i < 40; i++) shp.push_back(300);
        shp.push_back(100);
        run_pulse(1, 1'b0, 1'b1, "R4 long tail");
        shp = '{200, 500, 800, 700, 600, 100};
        run_pulse(2, 1'b0, 1'b1, "R4 level after tail");
        flat(100, 10);

        // R9 R10 R11: stall, hold, discard
        hit_ready = 1'b0;
        shp = '{200, 500, 800, 700, 600, 100};
        run_pulse(2, 1'b0, 1'b1, "R10 held");
        begin
            longint held_ts;
            int     held_amp;
            held_ts  = last_ts;
            held_amp = last_amp;
            @(negedge clk);
            chk(hit_valid == 1'b0, "R9 not yet valid on closing sample", longint'(hit_valid), 0);
            flat(100, 1);
            @(negedge clk);
            chk(hit_valid == 1'b1, "R9 valid after closing edge", longint'(hit_valid), 1);
            chk(longint'(hit_ts) == held_ts, "R9 ts at first valid cycle", longint'(hit_ts), held_ts);
            flat(100, 6);
            @(negedge clk);
            chk(hit_valid == 1'b1, "R10 still valid when stalled", longint'(hit_valid), 1);
            chk(longint'(hit_ts) == held_ts, "R10 ts held", longint'(hit_ts), held_ts);
            shp = '{300, 1200, 1100, 1000, 100};
            run_pulse(1, 1'b0, 1'b0, "R11 dropped");
            flat(100, 3);
            @(negedge clk);
            chk(longint'(hit_ts) == held_ts, "R11 ts kept", longint'(hit_ts), held_ts);
            chk(int'(hit_amp) == held_amp, "R11 amp kept", longint'(hit_amp), held_amp);
        end
        hit_ready = 1'b1;
        flat(100, 6);

        // R2: drift up then down, amplitudes follow the model level
        flat(140, 60);
        chk(bl == 125, "R2 model level after upward drift", bl, 125);
        shp = '{300, 600, 500, 400, 140};
        run_pulse(1, 1'b0, 1'b1, "R2 up");
        flat(90, 80);
        shp = '{300, 700, 600, 500, 90};
        run_pulse(1, 1'b0, 1'b1, "R2 down");
        flat(90, 10);
        chk(q_ts.size() == 0, "R9 all records delivered", q_ts.size(), 0);

        // R1: second reset primes the level from the first sample
        do_reset(400);
        @(negedge clk);
        chk(hit_valid == 1'b0, "R1 valid after second reset", longint'(hit_valid), 0);
        flat(400, 10);
        shp = '{600, 900, 800, 700, 400};
        run_pulse(1, 1'b0, 1'b1, "R1 primed level");
        flat(400, 10);
        chk(q_ts.size() == 0, "R1 record after reset delivered", q_ts.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule